// File: doc/BRIEF.md
# Most-significant-digit-first dot-product sign detector

The block makes hard bit decisions for a spreading-code matched filter. Each symbol it takes a vector of received samples for every lane and one shared vector of channel-estimate coefficients. It forms their dot product one radix-4 digit at a time, starting from the most significant digit. The samples are fed to the digit-by-vector multipliers most significant digit first, and the products of all taps go through an adder tree into a carry-free recurrence. That recurrence emits one redundant result digit in {-3..+3} per step. The sign of the first nonzero result digit is the detected bit, so the value is never converted back to binary and the low-order digits are never computed once the sign is known.

The two lanes carry the in-phase and quadrature halves of a QPSK symbol, and each lane makes its own BPSK decision. A mode input picks the stopping rule for each symbol. Truncated mode always runs a fixed number of digit steps and trades error rate for constant throughput. Variable mode stops as soon as every lane has seen a nonzero digit, so its decision is exact. A lane that has already decided stops updating its residual, and its registers are held by a clock enable. After each decision the block spends one cycle clearing every residual register, and only then does it accept the next symbol.

Top module: `odsd_sign_detect`

## Requirements
- R1: During reset and on the first cycle after it, in_ready is 1 and dec_valid is 0.
- R2: A symbol is taken on a rising edge with in_valid and in_ready both 1. in_ready is 0 from the next cycle on, stays 0 while dec_valid is 1, and returns to 1 on the cycle after dec_valid (the clearing slot).
- R3: Lane l reads its N_TAPS 8-bit two's complement samples from samp[l*32 +: 32] (tap k at bits [8k+7:8k]). The coefficients come from coef with the same tap layout and are shared by both lanes. Lane l reports on dec_neg[l] and dec_zero[l], and its result depends on nothing else.
- R4: Truncated mode (mode=0). For each lane, let P_j = sum over k of coef_k * floor(samp_k / 4^(4-j)) for j <= 4, and P_j = 4^(j-4) * D for j > 4, where D = P_4 is the dot product. Let Z_j = floor((P_j + 512) / 1024). dec_neg = 1 (meaning -1) exactly when Z_j < 0 at the first j in {1, 2} where Z_j is nonzero.
- R5: In truncated mode, dec_valid rises exactly 2 cycles after the accepting edge, whatever the data.
- R6: Variable mode (mode=1). dec_neg = 1 exactly when D < 0.
- R7: In variable mode, dec_valid rises L cycles after the accepting edge. L is the largest, over both lanes, of the first j with Z_j nonzero, where a lane with no such j up to 9 counts as 9.
- R8: A lane with no nonzero digit by its cutoff gives dec_zero = 1 and dec_neg = 0 (the default +1). In variable mode this happens exactly when D = 0.
- R9: dec_valid is 1 for exactly one cycle per accepted symbol and never without one.
- R10: in_valid and the data inputs are ignored while a symbol is in progress. They change neither the decision nor its timing, and no extra decision follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new symbol is presented |
| in_ready | output | 1 | Block idle and able to take a symbol |
| mode | input | 1 | 0 = truncated stopping rule, 1 = variable stopping rule |
| samp | input | LANES*N_TAPS*SAMP_W | Received samples, lane-major then tap-major |
| coef | input | N_TAPS*SAMP_W | Channel-estimate coefficients shared by the lanes |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_neg | output | LANES | Detected bit per lane, 1 means -1 |
| dec_zero | output | LANES | No nonzero digit seen before the cutoff |

## Verification
A full sweep of one sample value over all 256 codes, with strong coefficients, places the sign change and the rounding boundaries at every possible distance. This separates a wrong first-digit decomposition from a wrong rounding point. A full sweep of the shared coefficient against fixed, unlike lane vectors exercises sign inversion and keeps the two lanes apart. Random vectors, a few of them overwritten with garbage input while the symbol is busy, cover mixed digit patterns and the ignore rule. Zero and full-scale vectors hit the default decision and the largest residuals. Every case runs in both modes, so the truncated-mode errors are told apart from the exact variable-mode decisions and from their differing latencies.

// File: rtl/odsd_pkg.sv
package odsd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_CLEAR = 2'd2
  } odsd_state_e;

  localparam logic MODE_TRUNC = 1'b0;
  localparam logic MODE_VAR   = 1'b1;

  // Extra zero-input digit steps after the last sample digit. They make
  // 4^steps exceed half the selection scale, so a nonzero dot product must
  // show a nonzero output digit before the cutoff.
  function automatic int guard_steps(int samp_w, int log_taps);
    return (samp_w + log_taps - 1) / 2 + 1;
  endfunction

endpackage

// File: rtl/odsd_digit_slice.sv
// Radix-4 MSDF digit of a two's complement sample for a given step.
// The first digit is signed (-2..1), later digits are 0..3, and steps
// past the last digit give 0.
module odsd_digit_slice #(
  parameter int W      = 8,
  parameter int STEP_W = 4
) (
  input  logic [W-1:0]      samp,
  input  logic [STEP_W-1:0] step,
  output logic signed [2:0] digit
);
  localparam int DIGITS = W / 2;

  always_comb begin
    digit = '0;
    for (int k = 1; k <= DIGITS; k++) begin
      if (step == STEP_W'(k)) begin
        if (k == 1) digit = {samp[W-1], samp[W-1 -: 2]};
        else        digit = {1'b0, samp[W-2*k+1 -: 2]};
      end
    end
  end
endmodule

// File: rtl/odsd_dvm.sv
// Digit-by-vector multiply: full coefficient times one digit in {-2..3},
// built from shifts and one add.
module odsd_dvm #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] coef,
  input  logic signed [2:0]   digit,
  output logic signed [W+2:0] prod
);
  logic signed [W+2:0] c1, c2;

  assign c1 = {{3{coef[W-1]}}, coef};
  assign c2 = c1 <<< 1;

  always_comb begin
    case (digit)
      3'b001:  prod = c1;
      3'b010:  prod = c2;
      3'b011:  prod = c1 + c2;
      3'b110:  prod = -c2;
      3'b111:  prod = -c1;
      default: prod = '0;
    endcase
  end
endmodule

// File: rtl/odsd_sum_tree.sv
// Binary adder tree over N (power of two) sign-extended terms.
module odsd_sum_tree #(
  parameter int N     = 4,
  parameter int IN_W  = 11,
  parameter int OUT_W = 13
) (
  input  logic [N*IN_W-1:0]       terms,
  output logic signed [OUT_W-1:0] total
);
  logic signed [OUT_W-1:0] node [1:2*N-1];

  generate
    for (genvar g = 0; g < N; g++) begin : g_leaf
      assign node[N+g] = OUT_W'($signed(terms[g*IN_W +: IN_W]));
    end
    for (genvar k = 1; k < N; k++) begin : g_add
      assign node[k] = node[2*k] + node[2*k+1];
    end
  endgenerate

  assign total = node[1];
endmodule

// File: rtl/odsd_lane.sv
// One BPSK lane: MSDF digit extraction, digit-vector products, adder tree
// and the radix-4 residual recurrence with round-half-up digit selection.
module odsd_lane
  import odsd_pkg::*;
#(
  parameter int N      = 4,
  parameter int W      = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic [STEP_W-1:0] step,
  input  logic [N*W-1:0]    samp,
  input  logic [N*W-1:0]    coef,
  output logic              fin_dec,
  output logic              fin_neg
);
  localparam int LOGN   = $clog2(N);
  localparam int SH     = W + LOGN;
  localparam int RES_W  = SH + 3;
  localparam int PROD_W = W + 3;
  localparam logic signed [RES_W:0] HALF = (RES_W+1)'(1) <<< (SH - 1);

  logic signed [2:0]       dig [N];
  logic [N*PROD_W-1:0]     prods;
  logic signed [RES_W-1:0] step_sum;

  generate
    for (genvar g = 0; g < N; g++) begin : g_tap
      logic signed [PROD_W-1:0] p;
      odsd_digit_slice #(.W(W), .STEP_W(STEP_W)) u_slice (
        .samp  (samp[g*W +: W]),
        .step  (step),
        .digit (dig[g])
      );
      odsd_dvm #(.W(W)) u_mul (
        .coef  ($signed(coef[g*W +: W])),
        .digit (dig[g]),
        .prod  (p)
      );
      assign prods[g*PROD_W +: PROD_W] = p;
    end
  endgenerate

  odsd_sum_tree #(.N(N), .IN_W(PROD_W), .OUT_W(RES_W)) u_tree (
    .terms (prods),
    .total (step_sum)
  );

  logic signed [RES_W-1:0] w_q;
  logic                    decided_q, neg_q;
  logic signed [RES_W:0]   v, vh, w_n;
  logic signed [3:0]       z;

  assign v   = ((RES_W+1)'(w_q) <<< 2) + (RES_W+1)'(step_sum);
  assign vh  = v + HALF;
  assign z   = 4'(vh >>> SH);
  assign w_n = v - ((RES_W+1)'(z) <<< SH);

  // Once decided the residual is frozen (clock enable off).
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      w_q       <= '0;
      decided_q <= 1'b0;
      neg_q     <= 1'b0;
    end else if (run && !decided_q) begin
      w_q <= RES_W'(w_n);
      if (z != 4'sd0) begin
        decided_q <= 1'b1;
        neg_q     <= z[3];
      end
    end
  end

  assign fin_dec = decided_q | (z != 4'sd0);
  assign fin_neg = decided_q ? neg_q : z[3];
endmodule

// File: rtl/odsd_sign_detect.sv
module odsd_sign_detect
  import odsd_pkg::*;
#(
  parameter int N_TAPS       = 4,
  parameter int SAMP_W       = 8,
  parameter int TRUNC_DIGITS = 2,
  parameter int LANES        = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic                             mode,
  input  logic [LANES*N_TAPS*SAMP_W-1:0]   samp,
  input  logic [N_TAPS*SAMP_W-1:0]         coef,
  output logic                             dec_valid,
  output logic [LANES-1:0]                 dec_neg,
  output logic [LANES-1:0]                 dec_zero
);
  localparam int LOGN      = $clog2(N_TAPS);
  localparam int DIGITS    = SAMP_W / 2;
  localparam int MAX_STEPS = DIGITS + guard_steps(SAMP_W, LOGN);
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);
  localparam int VEC_W     = N_TAPS * SAMP_W;

  odsd_state_e                   state;
  logic [STEP_W-1:0]             step;
  logic                          mode_q;
  logic [LANES*VEC_W-1:0]        samp_q;
  logic [VEC_W-1:0]              coef_q;
  logic [LANES-1:0]              fin_dec, fin_neg;
  logic                          run, clr, last;

  assign run = (state == ST_RUN);
  assign clr = (state == ST_CLEAR);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      odsd_lane #(.N(N_TAPS), .W(SAMP_W), .STEP_W(STEP_W)) u_lane (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .run     (run),
        .step    (step),
        .samp    (samp_q[l*VEC_W +: VEC_W]),
        .coef    (coef_q),
        .fin_dec (fin_dec[l]),
        .fin_neg (fin_neg[l])
      );
    end
  endgenerate

  always_comb begin
    if (mode_q == MODE_TRUNC) last = (step == STEP_W'(TRUNC_DIGITS));
    else                      last = (&fin_dec) || (step == STEP_W'(MAX_STEPS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step      <= '0;
      mode_q    <= MODE_TRUNC;
      samp_q    <= '0;
      coef_q    <= '0;
      in_ready  <= 1'b1;
      dec_valid <= 1'b0;
      dec_neg   <= '0;
      dec_zero  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid && in_ready) begin
            samp_q   <= samp;
            coef_q   <= coef;
            mode_q   <= mode;
            step     <= STEP_W'(1);
            in_ready <= 1'b0;
            state    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (last) begin
            dec_valid <= 1'b1;
            dec_neg   <= fin_dec & fin_neg;
            dec_zero  <= ~fin_dec;
            state     <= ST_CLEAR;
          end else begin
            step <= step + STEP_W'(1);
          end
        end
        ST_CLEAR: begin
          dec_valid <= 1'b0;
          in_ready  <= 1'b1;
          step      <= '0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/odsd_sign_detect_chk.sv
module odsd_sign_detect_chk #(
  parameter int N_TAPS       = 4,
  parameter int SAMP_W       = 8,
  parameter int TRUNC_DIGITS = 2,
  parameter int LANES        = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             mode,
  input logic             dec_valid,
  input logic [LANES-1:0] dec_neg,
  input logic [LANES-1:0] dec_zero
);
  localparam int MAX_STEPS = SAMP_W / 2 + (SAMP_W + $clog2(N_TAPS) - 1) / 2 + 1;

  logic       busy, mode_l;
  logic [7:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      mode_l <= 1'b0;
      cnt    <= '0;
    end else if (in_valid && in_ready) begin
      busy   <= 1'b1;
      mode_l <= mode;
      cnt    <= '0;
    end else if (busy) begin
      if (dec_valid)        busy <= 1'b0;
      else if (cnt != 8'hFF) cnt <= cnt + 8'd1;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !dec_valid));

  a_r2_drop_ready: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  a_r2_ready_after_slot: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> in_ready);

  a_r5_trunc_len: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !mode_l) |-> (cnt == 8'(TRUNC_DIGITS)));

  a_r7_var_bound: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && mode_l) |-> (cnt >= 8'd1 && cnt <= 8'(MAX_STEPS)));

  a_r8_default_plus: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> ((dec_zero & dec_neg) == '0));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  a_r9_only_after_accept: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> busy);

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);
endmodule

bind odsd_sign_detect odsd_sign_detect_chk #(
  .N_TAPS(N_TAPS), .SAMP_W(SAMP_W), .TRUNC_DIGITS(TRUNC_DIGITS), .LANES(LANES)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .mode(mode),
  .dec_valid(dec_valid), .dec_neg(dec_neg), .dec_zero(dec_zero)
);

// File: tb/odsd_sign_detect_tb.sv
`timescale 1ns/1ps
module odsd_sign_detect_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        mode = 1'b0;
  logic [63:0] samp = '0;
  logic [31:0] coef = '0;
  logic        dec_valid;
  logic [1:0]  dec_neg, dec_zero;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  odsd_sign_detect u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .mode(mode),
    .samp(samp), .coef(coef), .dec_valid(dec_valid), .dec_neg(dec_neg),
    .dec_zero(dec_zero)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tap(input logic [31:0] v, input int k);
    return int'($signed(v[8*k +: 8]));
  endfunction

  function automatic int prefix(input int r, input int j);
    if (j <= 4) return r >>> (2 * (4 - j));
    return r * (4 ** (j - 4));
  endfunction

  function automatic int pj(input logic [31:0] s, input logic [31:0] c, input int j);
    int acc = 0;
    for (int k = 0; k < 4; k++) acc += tap(c, k) * prefix(tap(s, k), j);
    return acc;
  endfunction

  function automatic int rnd(input int p);
    return (p + 512) >>> 10;
  endfunction

  function automatic int first_nz(input logic [31:0] s, input logic [31:0] c);
    for (int j = 1; j <= 9; j++) if (rnd(pj(s, c, j)) != 0) return j;
    return 0;
  endfunction

  task automatic apply(input logic m, input logic [63:0] s, input logic [31:0] c,
                       input bit poke);
    int k, lat, fj, jl;
    int en [2];
    int ez [2];
    int guard = 0;
    while (!in_ready && guard < 50) begin @(negedge clk); guard++; end
    in_valid = 1'b1; mode = m; samp = s; coef = c;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 ready low after accept", in_ready, 0);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (poke && k == 1) begin
        in_valid = 1'b1; samp = ~s; coef = ~c; mode = ~m;
      end
      if (!dec_valid) chk("R2 ready low while busy", in_ready, 0);
    end while (!dec_valid && k < 40);
    in_valid = 1'b0;
    lat = 0;
    for (int l = 0; l < 2; l++) begin
      fj = first_nz(s[32*l +: 32], c);
      jl = (fj == 0) ? 9 : fj;
      if (m == 1'b0) begin
        if (fj >= 1 && fj <= 2) begin
          ez[l] = 0;
          en[l] = (rnd(pj(s[32*l +: 32], c, fj)) < 0) ? 1 : 0;
        end else begin
          ez[l] = 1; en[l] = 0;
        end
      end else begin
        ez[l] = (pj(s[32*l +: 32], c, 4) == 0) ? 1 : 0;
        en[l] = (pj(s[32*l +: 32], c, 4) < 0) ? 1 : 0;
        if (jl > lat) lat = jl;
      end
    end
    if (m == 1'b0) chk(poke ? "R5 R10 trunc latency" : "R5 trunc latency", k, 2);
    else           chk(poke ? "R7 R10 var latency" : "R7 var latency", k, lat);
    chk(m ? "R6 lane0 sign" : "R4 lane0 sign", dec_neg[0], en[0]);
    chk(m ? "R6 R3 lane1 sign" : "R4 R3 lane1 sign", dec_neg[1], en[1]);
    chk("R8 lane0 zero flag", dec_zero[0], ez[0]);
    chk("R8 R3 lane1 zero flag", dec_zero[1], ez[1]);
    @(negedge clk);
    chk("R9 strobe one cycle", dec_valid, 0);
    chk("R2 ready after clear slot", in_ready, 1);
  endtask

  function automatic logic [31:0] fill(input logic [7:0] b);
    return {b, b, b, b};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", in_ready, 1);
    chk("R1 no strobe in reset", dec_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", in_ready, 1);
    chk("R1 no strobe after reset", dec_valid, 0);

    for (int m = 0; m < 2; m++) begin
      apply(m[0], '0, fill(8'd77), 0);
      apply(m[0], {fill(8'h80), fill(8'h80)}, fill(8'h80), 0);
      apply(m[0], {fill(8'h7F), fill(8'h80)}, fill(8'h80), 0);
      for (int r = -128; r < 128; r++) begin
        logic [7:0] b = 8'(r);
        apply(m[0], {fill(~b), fill(b)}, fill(8'd127), 0);
      end
      for (int x = -128; x < 128; x++) begin
        apply(m[0], {32'h0000_0001, 32'h80_07_FD_64}, fill(8'(x)), 0);
      end
      for (int i = 0; i < 300; i++) begin
        logic [63:0] rs = {$urandom(), $urandom()};
        logic [31:0] rc = $urandom();
        apply(m[0], rs, rc, (i % 4) == 0);
      end
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule